// File: doc/BRIEF.md
# Nibble-Serial Clock Register Port

This block is the CPU side of a real-time-clock register file that holds sixteen 4-bit registers. The CPU sees three byte locations: a select location, a 4-bit data port and a fixed status location. Each transaction begins with a select. The first nibble written to the data port sets the direction of the transaction. The second nibble gives the starting register. After that, any number of nibbles can be read or written, and the register index advances after each one.

Registers 0 to 12 are the time fields, stored as BCD digits from the seconds ones digit up to the year tens digit, followed by the day of week. The AM/PM flag is kept in register 5. Registers 13 to 15 are three control registers, which the block stores and places on an output. The time counting itself sits outside this block and supplies its present value on an input vector. The block copies that vector when a transaction starts, so every read in the transaction sees the same instant. If a transaction wrote any time register, the block offers the edited set of time registers back to the counter with a one-cycle strobe after the deselect.

Top module: `rtc_nibble_port`

## Requirements
- R1: After reset the port is deselected, the strobe is low, all three control registers read as zero on `ctrl_out`, and a data-port read returns 0x00.
- R2: A write to location 0 with `bus_wdata[0]`=1 while deselected opens a transaction. It copies `time_now[4k+3:4k]` into register k for k = 0..12. Writing 1 while already selected changes nothing.
- R3: The first data-port write (location 1) after select is the command. 0xC selects read and 0x3 selects write. Any other value leaves the transaction inert: its data reads return 0x00 and its data writes store nothing.
- R4: The second data-port write sets the starting register index.
- R5: In a read transaction, each data-port read returns `{4'h0, reg[index]}` and then advances the index by one, wrapping from 15 to 0.
- R6: In a write transaction, each further data-port write stores `bus_wdata[3:0]` into `reg[index]` and then advances the index with the same wrap.
- R7: A read of location 2 returns 0x80. A read of location 0 or 3 returns 0x00.
- R8: A data-port read returns 0x00 and does not advance the index in any of these cases: while deselected, during the command or index phase, or in a write transaction. Data-port writes while deselected are ignored.
- R9: A write of 0 to location 0 while selected closes the transaction. If the transaction stored into any of registers 0..12, `time_load_stb` is high for exactly the next cycle, and at that time `time_load` carries registers 0..12 packed like `time_now`. Otherwise no strobe is produced.
- R10: Registers 13..15 are not touched by the select-time copy. They keep their values across transactions and appear on `ctrl_out` as `{reg15, reg14, reg13}`.
- R11: Changes on `time_now` during an open transaction do not alter the values that its reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Location: 0 select, 1 data, 2 status |
| bus_wdata | input | 4 | Write data (bit 0 only for select) |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| time_now | input | 52 | Current time, nibble k for register k |
| time_load | output | 52 | Edited time registers, packed like `time_now` |
| time_load_stb | output | 1 | One-cycle pulse when `time_load` should be taken |
| ctrl_out | output | 12 | Control registers 15, 14, 13 |

## Verification
The bench steps runs of reads and writes across the 15-to-0 index wrap. A design that fails to wrap, or that advances the index by the wrong amount, returns shifted register values. It also reads the data port while deselected, during the command and index phases, and inside write transactions. A design that leaks stored values there, or that moves the index on those reads, is caught by the read that follows. Further cases check that `time_now` changes in mid-transaction do not show in the reads, that a second select-1 does not re-copy the time, and that a transaction writing only control registers, or one with an unknown command, closes without a strobe.

// File: rtl/rtc_nibble_port.sv
module rtc_nibble_port #(
  parameter logic [3:0] RD_CMD     = 4'hC,
  parameter logic [3:0] WR_CMD     = 4'h3,
  parameter logic [7:0] READY_CODE = 8'h80,
  parameter int         NTIME      = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [3:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [51:0] time_now,
  output logic [51:0] time_load,
  output logic        time_load_stb,
  output logic [11:0] ctrl_out
);
  typedef enum logic [1:0] {PH_CMD, PH_IDX, PH_DATA} phase_t;

  logic       sel_q, rd_op_q, wr_op_q, dirty_q, stb_q;
  phase_t     phase_q;
  logic [3:0] idx_q;
  logic [3:0] regs_q [16];

  wire sel_wr  = bus_wr && bus_addr == 2'd0;
  wire data_wr = bus_wr && bus_addr == 2'd1;
  wire data_rd = bus_rd && !bus_wr && bus_addr == 2'd1;
  wire start   = sel_wr && bus_wdata[0] && !sel_q;
  wire stop    = sel_wr && !bus_wdata[0] && sel_q;
  wire in_data = sel_q && phase_q == PH_DATA;
  wire rd_live = in_data && rd_op_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        2'd1:    bus_rdata = rd_live ? {4'h0, regs_q[idx_q]} : 8'h00;
        2'd2:    bus_rdata = READY_CODE;
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      rd_op_q <= 1'b0;
      wr_op_q <= 1'b0;
      dirty_q <= 1'b0;
      stb_q   <= 1'b0;
      phase_q <= PH_CMD;
      idx_q   <= 4'h0;
      for (int k = 0; k < 16; k++) regs_q[k] <= 4'h0;
    end else begin
      stb_q <= 1'b0;
      if (start) begin
        sel_q   <= 1'b1;
        phase_q <= PH_CMD;
        rd_op_q <= 1'b0;
        wr_op_q <= 1'b0;
        dirty_q <= 1'b0;
        for (int k = 0; k < NTIME; k++) regs_q[k] <= time_now[4*k +: 4];
      end else if (stop) begin
        sel_q   <= 1'b0;
        stb_q   <= dirty_q;
        dirty_q <= 1'b0;
      end else if (data_wr && sel_q) begin
        case (phase_q)
          PH_CMD: begin
            rd_op_q <= bus_wdata == RD_CMD;
            wr_op_q <= bus_wdata == WR_CMD;
            phase_q <= PH_IDX;
          end
          PH_IDX: begin
            idx_q   <= bus_wdata;
            phase_q <= PH_DATA;
          end
          default: if (wr_op_q) begin
            regs_q[idx_q] <= bus_wdata;
            idx_q         <= idx_q + 4'd1;
            if (int'(idx_q) < NTIME) dirty_q <= 1'b1;
          end
        endcase
      end else if (data_rd && rd_live) begin
        idx_q <= idx_q + 4'd1;
      end
    end
  end

  for (genvar k = 0; k < NTIME; k++) begin : g_load
    assign time_load[4*k +: 4] = regs_q[k];
  end

  assign time_load_stb = stb_q;
  assign ctrl_out      = {regs_q[15], regs_q[14], regs_q[13]};
endmodule

// File: rtl/rtc_nibble_port_chk.sv
module rtc_nibble_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       wdata0,
  input logic [7:0] bus_rdata,
  input logic [3:0] now0,
  input logic       time_load_stb,
  input logic       sel_q,
  input logic       rd_live,
  input logic [3:0] idx_q,
  input logic [3:0] reg0
);
  p_ready_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == 2'd2 |-> bus_rdata == 8'h80);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd1 |-> bus_rdata[7:4] == 4'h0);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == 2'd1 && !rd_live |-> bus_rdata == 8'h00);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == 2'd1 && rd_live |=> idx_q == $past(idx_q) + 4'd1);

  p_snapshot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd0 && wdata0 && !sel_q |=> reg0 == $past(now0));

  p_stb_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    time_load_stb |-> $past(bus_wr && bus_addr == 2'd0 && !wdata0 && sel_q));

  p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    time_load_stb |=> !time_load_stb);
endmodule

bind rtc_nibble_port rtc_nibble_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wdata0(bus_wdata[0]), .bus_rdata(bus_rdata),
  .now0(time_now[3:0]), .time_load_stb(time_load_stb), .sel_q(sel_q),
  .rd_live(rd_live), .idx_q(idx_q), .reg0(regs_q[0])
);

// File: tb/rtc_nibble_port_tb_top.sv
module rtc_nibble_port_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_wdata = 4'h0;
  logic [7:0]  bus_rdata;
  logic [51:0] time_now = '0;
  logic [51:0] time_load;
  logic        time_load_stb;
  logic [11:0] ctrl_out;

  int n_chk = 0, n_err = 0;

  // reference model state
  bit m_sel = 0, m_dirty = 0, m_stb = 0;
  int m_phase = 0, m_mode = 0, m_idx = 0;
  int m_regs [16];

  always #(PERIOD/2) clk = ~clk;

  rtc_nibble_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_now(time_now), .time_load(time_load),
    .time_load_stb(time_load_stb), .ctrl_out(ctrl_out)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [51:0] pack_time();
    logic [51:0] v;
    for (int k = 0; k < 13; k++) v[4*k +: 4] = 4'(m_regs[k]);
    return v;
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [3:0] d);
    if (a == 2'd0) begin
      if (d[0] && !m_sel) begin
        m_sel = 1; m_phase = 0; m_mode = 0; m_dirty = 0;
        for (int k = 0; k < 13; k++) m_regs[k] = int'(time_now[4*k +: 4]);
      end else if (!d[0] && m_sel) begin
        m_sel = 0; m_stb = m_dirty; m_dirty = 0;
      end
    end else if (a == 2'd1 && m_sel) begin
      if (m_phase == 0) begin
        m_mode = (d == 4'hC) ? 1 : (d == 4'h3) ? 2 : 0;
        m_phase = 1;
      end else if (m_phase == 1) begin
        m_idx = int'(d); m_phase = 2;
      end else if (m_mode == 2) begin
        m_regs[m_idx] = int'(d);
        if (m_idx < 13) m_dirty = 1;
        m_idx = (m_idx + 1) % 16;
      end
    end
  endtask

  task automatic op_wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic op_rd(input logic [1:0] a, input string req);
    logic [7:0] exp;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1;
    exp = 8'h00;
    if (a == 2'd2) exp = 8'h80;
    else if (a == 2'd1 && m_sel && m_phase == 2 && m_mode == 1) begin
      exp = 8'(m_regs[m_idx]);
      m_idx = (m_idx + 1) % 16;
    end
    chk(64'(bus_rdata), 64'(exp), req);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  // per-clock comparison of the free-running outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk(64'(time_load_stb), 64'(m_stb), "R9 strobe");
      if (m_stb) chk(64'(time_load), 64'(pack_time()), "R9 time_load");
      chk(64'(ctrl_out), 64'({m_regs[15][3:0], m_regs[14][3:0], m_regs[13][3:0]}), "R10 ctrl_out");
      m_stb = 0;
    end
  end

  initial begin
    #(PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) m_regs[k] = 0;
    for (int k = 0; k < 13; k++) time_now[4*k +: 4] = 4'(k * 3 + 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state, R7 fixed locations
    op_rd(2'd1, "R1 data after reset");
    chk(64'(time_load_stb), 64'd0, "R1 strobe low");
    chk(64'(ctrl_out), 64'd0, "R1 ctrl zero");
    op_rd(2'd2, "R7 status");
    op_rd(2'd0, "R7 select location");
    op_rd(2'd3, "R7 location 3");

    // R2 snapshot, R3 read command, R4 start index, R5 full wrap
    op_wr(2'd0, 4'h1);
    op_rd(2'd1, "R8 read in command phase");
    op_wr(2'd1, 4'hC);
    op_rd(2'd1, "R8 read in index phase");
    op_wr(2'd1, 4'h7);
    for (int i = 0; i < 18; i++) op_rd(2'd1, "R5 R4 read run");
    op_wr(2'd0, 4'h1);                     // R2 second select: no effect
    time_now = ~time_now;                  // R11 change mid-transaction
    for (int i = 0; i < 6; i++) op_rd(2'd1, "R11 R2 stable snapshot");
    op_wr(2'd0, 4'h0);

    // R6 write run across the wrap, R9 strobe with edited registers
    op_wr(2'd0, 4'h1);
    op_wr(2'd1, 4'h3);
    op_wr(2'd1, 4'hB);
    op_rd(2'd1, "R8 read in write transaction");
    for (int i = 0; i < 7; i++) op_wr(2'd1, 4'(9 + i));
    op_wr(2'd0, 4'h0);
    repeat (2) @(posedge clk);

    // R10 control registers survive a new snapshot; R6 stored values read back
    for (int k = 0; k < 13; k++) time_now[4*k +: 4] = 4'(k * 5 + 2);
    op_wr(2'd0, 4'h1);
    op_wr(2'd1, 4'hC);
    op_wr(2'd1, 4'hA);
    for (int i = 0; i < 8; i++) op_rd(2'd1, "R10 R6 readback");
    op_wr(2'd0, 4'h0);

    // R3 unknown command: inert
    op_wr(2'd0, 4'h1);
    op_wr(2'd1, 4'h5);
    op_wr(2'd1, 4'hD);
    op_wr(2'd1, 4'hF);
    op_rd(2'd1, "R3 unknown command read");
    op_wr(2'd1, 4'hE);
    op_wr(2'd0, 4'h0);

    // R9 writing only control registers gives no strobe
    op_wr(2'd0, 4'h1);
    op_wr(2'd1, 4'h3);
    op_wr(2'd1, 4'hD);
    op_wr(2'd1, 4'h4);
    op_wr(2'd1, 4'h6);
    op_wr(2'd0, 4'h0);
    repeat (2) @(posedge clk);

    // R8 data writes and reads while deselected
    op_wr(2'd1, 4'h3);
    op_wr(2'd1, 4'hD);
    op_wr(2'd1, 4'h1);
    op_rd(2'd1, "R8 deselected read");
    op_wr(2'd0, 4'h1);
    op_wr(2'd1, 4'hC);
    op_wr(2'd1, 4'hD);
    for (int i = 0; i < 3; i++) op_rd(2'd1, "R8 R10 ctrl after ignored writes");
    op_wr(2'd0, 4'h0);
    repeat (3) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule